// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block watches two clocks divided from one source clock, bank A and bank C. Their divide ratios need not be integer multiples of each other, so their rising edges line up only now and then. The block drives an active-low marker, `sync_n`, that goes low for one period of the faster of the two divided clocks. That low period sits directly ahead of the next rising edge the two clocks share, and `sync_n` returns high on that shared edge. Downstream logic can use this rising edge to find the common alignment point, whatever ratio pair is selected.

The block rebuilds the phase of each divided clock with one counter per bank. It places the pulse from how the two phases relate, so no least-common-multiple arithmetic is needed in hardware. New divide ratios are taken only on a shared edge. After a reload, and after reset, the marker stays high for one whole coincidence period so that the alignment can settle.

Timing convention: the source cycle after the clock edge that releases reset is phase 1, and phase 0 is a shared rising edge of A and C. One coincidence period is L = lcm(Na, Nc) source cycles. F = min(Na, Nc) is one period of the faster clock.

Top module: `coinc_sync_gen`

## Requirements
- R1: With unequal ratios, every low pulse of `sync_n` lasts exactly F source cycles, where F is the smaller of the two divide ratios in force.
- R2: Outside the hold-off, `sync_n` is low in the cycles at phases L−F through L−1 of each coincidence period.
- R3: Outside the hold-off, `sync_n` is high at every other phase, and its rising edge falls on phase 0, the shared rising edge of A and C.
- R4: When the two ratios are equal, every edge is shared, so `sync_n` stays low continuously once the hold-off has ended.
- R5: While `rst_n` is low (synchronous, active low), `sync_n` is high and the ratios on `div_a`/`div_c` are captured as the ratios in force.
- R6: After reset is released, `sync_n` stays high for the whole first coincidence period, phases 1 through L.
- R7: `div_a` and `div_c` are sampled only on the clock edge that ends phase L−1. A change that is reverted before that edge has no effect on `sync_n`.
- R8: If the sampled ratios differ from those in force, the new ratios apply from the next phase 0, and `sync_n` stays high for one full new coincidence period.
- R9: Each ratio is an unsigned integer from 1 to 2^RW−1, where the value is the number of source cycles per divided period (0 is illegal). Coprime pairs and a ratio of 1 are supported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock that both divided clocks derive from |
| rst_n | input | 1 | Synchronous active-low reset |
| div_a | input | RW | Divide ratio of bank A, in source cycles |
| div_c | input | RW | Divide ratio of bank C, in source cycles |
| sync_n | output | 1 | Active-low marker, low for the faster period before a shared edge |

## Verification
A phase counter that slips by one cycle shifts the whole low window, and the comparison catches this in the first pulse after the hold-off. A ratio register loaded at the wrong time shows up in the same way: it either cuts the hold-off short or bends the window within one coincidence period. A hold-off flag that does not clear shows as a missing pulse one period after release. A fault in the window compare changes the length of the pulse, and the length check flags this when the marker next rises. Because the model is compared against the output on every source cycle, no fault stays hidden for longer than two coincidence periods.

// File: rtl/coinc_sync_pkg.sv
// Package: shared width type and window predicate for the coincident-edge
// sync generator. Assumes ratio widths never exceed WIDE_W bits.
package coinc_sync_pkg;

    localparam int WIDE_W = 16;

    typedef logic [WIDE_W-1:0] wide_t;

    // True when phases (ca, cc) under ratios (na, nc) sit inside the final
    // faster-clock period before the shared rising edge.
    function automatic logic lead_window(input wide_t ca, input wide_t cc,
                                         input wide_t na, input wide_t nc);
        if (na <= nc) begin
            return cc == ca + (nc - na);
        end
        return ca == cc + (na - nc);
    endfunction

endpackage

// File: rtl/coinc_phase_ctr.sv
// Module: phase counter rebuilding one divided clock. It counts 0..ratio-1
// and flags the last phase. Assumes ratio >= 1 and that a new ratio only
// arrives while the counter is returning to 0.
module coinc_phase_ctr #(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio,
    output logic [RW-1:0] cnt_nxt,
    output logic          at_last
);

    logic [RW-1:0] cnt;

    // Last-phase detect and next phase value.
    always_comb begin
        at_last = (cnt == ratio - 1'b1);
        cnt_nxt = at_last ? '0 : cnt + 1'b1;
    end

    // Phase register, starts at 0 out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            cnt <= cnt_nxt;
        end
    end

endmodule

// File: rtl/coinc_ratio_ctl.sv
// Module: ratio holder and hold-off control. It captures the requested ratios
// in reset and at a shared wrap when they differ from those in force. It
// keeps the marker suppressed for the coincidence period that follows.
// Assumes the wrap is both phase counters at their last phase at once.
module coinc_ratio_ctl #(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] req_a,
    input  logic [RW-1:0] req_c,
    input  logic          last_a,
    input  logic          last_c,
    output logic [RW-1:0] ra,
    output logic [RW-1:0] rc,
    output logic [RW-1:0] ra_nxt,
    output logic [RW-1:0] rc_nxt,
    output logic          hold,
    output logic          hold_nxt
);

    logic wrap;
    logic changed;

    // Decide reload and hold-off for the next cycle.
    always_comb begin
        wrap     = last_a & last_c;
        changed  = (req_a != ra) | (req_c != rc);
        ra_nxt   = ra;
        rc_nxt   = rc;
        hold_nxt = hold;
        if (wrap) begin
            if (changed) begin
                ra_nxt   = req_a;
                rc_nxt   = req_c;
                hold_nxt = 1'b1;
            end else begin
                hold_nxt = 1'b0;
            end
        end
    end

    // Ratio and hold-off registers; reset captures the requested ratios.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra   <= req_a;
            rc   <= req_c;
            hold <= 1'b1;
        end else begin
            ra   <= ra_nxt;
            rc   <= rc_nxt;
            hold <= hold_nxt;
        end
    end

endmodule

// File: rtl/coinc_lead_window.sv
// Module: marker driver. It evaluates the lead window on next-cycle phases
// and ratios and registers the active-low marker. Assumes RW <= WIDE_W.
module coinc_lead_window
    import coinc_sync_pkg::*;
#(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ra_nxt,
    input  logic [RW-1:0] rc_nxt,
    input  logic [RW-1:0] ca_nxt,
    input  logic [RW-1:0] cc_nxt,
    input  logic          hold_nxt,
    output logic          sync_n
);

    logic in_win;

    // Window test on the values the counters take next cycle.
    always_comb begin
        in_win = lead_window(wide_t'(ca_nxt), wide_t'(cc_nxt),
                             wide_t'(ra_nxt), wide_t'(rc_nxt));
    end

    // Registered marker: high in reset and during hold-off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_n <= 1'b1;
        end else begin
            sync_n <= hold_nxt | ~in_win;
        end
    end

endmodule

// File: rtl/coinc_sync_gen.sv
// Module: top of the coincident-edge sync generator. It rebuilds the bank A
// and bank C phases and drives sync_n low for the faster period ahead of each
// shared rising edge. Assumes ratios of at least 1 and RW of at most 16.
module coinc_sync_gen #(
    parameter int RW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] div_a,
    input  logic [RW-1:0] div_c,
    output logic          sync_n
);

    localparam int NBANK = 2;

    logic [RW-1:0]             ra;
    logic [RW-1:0]             rc;
    logic [RW-1:0]             ra_nxt;
    logic [RW-1:0]             rc_nxt;
    logic                      hold;
    logic                      hold_nxt;
    logic [NBANK-1:0][RW-1:0]  ratio_now;
    logic [NBANK-1:0][RW-1:0]  phase_nxt;
    logic [NBANK-1:0]          at_last;

    // Index 0 is bank A, index 1 is bank C.
    assign ratio_now = {rc, ra};

    coinc_ratio_ctl #(.RW(RW)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_a    (div_a),
        .req_c    (div_c),
        .last_a   (at_last[0]),
        .last_c   (at_last[1]),
        .ra       (ra),
        .rc       (rc),
        .ra_nxt   (ra_nxt),
        .rc_nxt   (rc_nxt),
        .hold     (hold),
        .hold_nxt (hold_nxt)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        coinc_phase_ctr #(.RW(RW)) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .ratio   (ratio_now[b]),
            .cnt_nxt (phase_nxt[b]),
            .at_last (at_last[b])
        );
    end

    coinc_lead_window #(.RW(RW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .ra_nxt   (ra_nxt),
        .rc_nxt   (rc_nxt),
        .ca_nxt   (phase_nxt[0]),
        .cc_nxt   (phase_nxt[1]),
        .hold_nxt (hold_nxt),
        .sync_n   (sync_n)
    );

endmodule

// File: rtl/coinc_sync_chk.sv
// Module: property checker for coinc_sync_gen, attached by bind. It measures
// low-run length itself so that the pulse-width rule needs no long $past.
module coinc_sync_chk #(
    parameter int RW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sync_n,
    input logic          hold,
    input logic          last_a,
    input logic          last_c,
    input logic [RW-1:0] ra,
    input logic [RW-1:0] rc
);

    logic [RW:0]   low_run;
    logic [RW-1:0] fast_q;
    logic          eq_q;

    // Saturating count of consecutive low cycles, plus last cycle's ratios.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
            fast_q  <= '0;
            eq_q    <= 1'b0;
        end else begin
            if (!sync_n) begin
                low_run <= (&low_run) ? low_run : low_run + 1'b1;
            end else begin
                low_run <= '0;
            end
            fast_q <= (ra < rc) ? ra : rc;
            eq_q   <= (ra == rc);
        end
    end

    // R5: reset forces the marker high.
    p_reset_high_r5: assert property (@(posedge clk) !rst_n |=> sync_n);

    // R1: a pulse with unequal ratios lasts one faster period.
    p_pulse_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sync_n) && !eq_q) |-> (low_run == {1'b0, fast_q}));

    // R3: the marker rises only on a shared edge.
    p_rise_on_shared_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_n) |-> $past(last_a && last_c));

    // R8: no pulse while the hold-off is active.
    p_hold_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |-> sync_n);

    // R7: ratios in force change only across a shared wrap.
    p_ratio_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(last_a && last_c) |=> ($stable(ra) && $stable(rc)));

    // R4: equal ratios keep the marker low once the hold-off is over.
    p_equal_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && (ra == rc)) |-> !sync_n);

endmodule

bind coinc_sync_gen coinc_sync_chk #(.RW(RW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_n (sync_n),
    .hold   (hold),
    .last_a (at_last[0]),
    .last_c (at_last[1]),
    .ra     (ra),
    .rc     (rc)
);

// File: tb/coinc_sync_gen_tb.sv
// Bench: behavioural model using phase and lcm, compared every source cycle.
module coinc_sync_gen_tb;

    localparam int RW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] div_a = 6'd4;
    logic [RW-1:0] div_c = 6'd8;
    logic          sync_n;

    int vectors = 0;
    int fails = 0;
    int cyc = 0;
    int ma = 4, mc = 8, per = 8, ph = 0;
    bit hold_m = 1'b1, hold_rst = 1'b1, exp_s = 1'b1;
    int run = 0, fprev = 0;
    bit eqprev = 1'b0;
    string stage = "R5";

    always #10 clk = ~clk;

    coinc_sync_gen #(.RW(RW)) u_dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .div_a  (div_a),
        .div_c  (div_c),
        .sync_n (sync_n)
    );

    function automatic int gcd(int a, int b);
        int x = a, y = b;
        while (y != 0) begin
            int t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int lcm(int a, int b);
        return (a / gcd(a, b)) * b;
    endfunction

    function automatic string tag_of();
        if (!rst_n) return "R5";
        if (hold_m && hold_rst) return "R6";
        if (hold_m) return "R8";
        if (ma == mc) return "R4";
        if (!exp_s) return "R2";
        return "R3";
    endfunction

    // Model update on the edge, comparison 2 ns later.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ma = int'(div_a); mc = int'(div_c);
            per = lcm(ma, mc); ph = 0;
            hold_m = 1'b1; hold_rst = 1'b1; exp_s = 1'b1;
        end else begin
            ph++;
            if (ph == per) begin
                ph = 0;
                if (int'(div_a) != ma || int'(div_c) != mc) begin
                    ma = int'(div_a); mc = int'(div_c);
                    per = lcm(ma, mc);
                    hold_m = 1'b1; hold_rst = 1'b0;
                end else begin
                    hold_m = 1'b0;
                end
            end
            exp_s = hold_m ? 1'b1 : !(ph >= per - ((ma < mc) ? ma : mc));
        end
        #2;
        vectors++;
        if (sync_n !== exp_s) begin
            fails++;
            $display("FAIL %s (stage %s) cycle %0d: sync_n=%0b expected %0b",
                     tag_of(), stage, cyc, sync_n, exp_s);
        end
        // R1: measured pulse length at each rising edge of the marker.
        if (!rst_n) begin
            run = 0;
        end else if (sync_n === 1'b0) begin
            run++;
        end else begin
            if (run > 0 && !eqprev) begin
                vectors++;
                if (run != fprev) begin
                    fails++;
                    $display("FAIL R1 cycle %0d: pulse length=%0d expected %0d",
                             cyc, run, fprev);
                end
            end
            run = 0;
        end
        fprev  = (ma < mc) ? ma : mc;
        eqprev = (ma == mc);
    end

    // Watchdog.
    always @(posedge clk) begin
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: run hung at cycle %0d, expected end", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_ratio(int a, int c, int n);
        div_a = RW'(a);
        div_c = RW'(c);
        step(n);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1; stage = "R6";
        step(60);
        stage = "R2";
        step(40);
        set_ratio(12, 4, 120);
        set_ratio(12, 8, 150);
        set_ratio(16, 4, 100);
        stage = "R3";
        set_ratio(8, 6, 120);
        set_ratio(24, 4, 150);
        stage = "R4";
        set_ratio(4, 4, 60);
        stage = "R9";
        set_ratio(3, 5, 90);
        set_ratio(1, 3, 30);
        set_ratio(1, 1, 20);
        stage = "R8";
        set_ratio(6, 10, 100);
        stage = "R7";
        while (ph != 5) @(negedge clk);
        set_ratio(2, 2, 5);
        set_ratio(6, 10, 100);
        stage = "R5";
        div_a = 6'd5; div_c = 6'd3;
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1; stage = "R6";
        step(80);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule